// File: doc/BRIEF.md
# AES Forward Substitution Byte Unit

This block computes the forward AES substitution of one byte. The byte enters in the standard AES field, which is defined by the polynomial x^8+x^4+x^3+x+1. A linear map carries it into a two-level composite field. The composite field is built as a quadratic extension over a sixteen-element subfield, and each subfield value is held as five bits in the cyclic ring modulo x^5+1. Because this representation is redundant, squaring is only a rewiring of bits and multiplication is a cyclic convolution.

The inverse is found by reducing the byte to its norm in the subfield, inverting that norm, and multiplying it by the conjugate. A single binary matrix then takes the ten redundant bits straight back to the AES field and applies the AES affine step in the same pass. An XOR with the constant 0x63 completes the result. Both conversion matrices are derived from the field definitions at elaboration. Among the eight roots that could anchor the field isomorphism, the one whose input matrix has the lowest worst-case row weight is chosen.

One input byte is accepted per cycle. The result is registered. An optional register placed after the subfield inversion splits the logic depth roughly in half.

Top module: `sbx_subbytes`

## Requirements
- R1: While `rst` is high at a rising edge, `dout_vld` and `dout` are both 0 after that edge.
- R2: For every input byte x, `dout` equals the AES S-box value: the multiplicative inverse of x modulo x^8+x^4+x^3+x+1 (0 maps to 0), passed through the affine step s = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, where rotl rotates the 8-bit value left and bit 0 is the least significant bit.
- R3: Input 0x00 yields 0x63.
- R4: A byte presented with `din_vld` high at a rising edge appears on `dout`, with `dout_vld` high, exactly 1+MID_REG rising edges later. `dout_vld` is high exactly once per accepted byte.
- R5: When no accepted byte reaches the output, `dout_vld` is low and `dout` keeps its previous value, whatever `din` carries.
- R6: Bytes presented on consecutive cycles come out on consecutive cycles, in the same order.
- R7: A nonzero input never produces the value reserved for zero (0x63): the composite-field norm and the inverse of any nonzero byte are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din_vld | input | 1 | `din` holds a byte to substitute this cycle |
| din | input | 8 | Byte in the AES field |
| dout_vld | output | 1 | `dout` holds a fresh result |
| dout | output | 8 | Substituted byte |

## Verification
Several properties are checked on every cycle by the assertions. The norm of any nonzero composite element must be nonzero, and the subfield inverse must multiply back to one. The isomorphism must never send a nonzero byte to zero, and a zero input to the output map must give the affine constant. The valid flag must trail the input by the configured latency, and the output must stay still when no result arrives. Only the bench scenarios can show that the two derived matrices agree with the real S-box over all 256 values, that results leave in order under back-to-back traffic, and that stray `din` values during idle gaps leave no trace.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

  localparam int SUB_W  = 5;          // redundant subfield width (ring mod x^5+1)
  localparam int SUB_C  = SUB_W - 1;  // canonical subfield width
  localparam int TWR_W  = 2 * SUB_W;  // composite element width
  localparam int BYTE_W = 8;

  typedef logic [SUB_W-1:0]  sub_t;
  typedef logic [SUB_C-1:0]  subc_t;
  typedef logic [TWR_W-1:0]  twr_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BYTE_W-1:0][TWR_W-1:0] fwd_mat_t;
  typedef logic [TWR_W-1:0][BYTE_W-1:0] out_mat_t;

  // cyclic convolution: product in GF(2)[x]/(x^5+1)
  function automatic sub_t sub_mul(sub_t a, sub_t b);
    sub_t r;
    r = '0;
    for (int i = 0; i < SUB_W; i++)
      for (int j = 0; j < SUB_W; j++)
        r[(i + j) % SUB_W] = r[(i + j) % SUB_W] ^ (a[i] & b[j]);
    return r;
  endfunction

  // squaring is a pure bit permutation: i -> 2i mod 5
  function automatic sub_t sub_sq(sub_t a);
    sub_t r;
    r = '0;
    for (int i = 0; i < SUB_W; i++)
      r[(2 * i) % SUB_W] = a[i];
    return r;
  endfunction

  // a^14 = a^2 * a^4 * a^8 ; zero (either form) stays zero
  function automatic sub_t sub_inv(sub_t a);
    sub_t s1, s2, s3;
    s1 = sub_sq(a);
    s2 = sub_sq(s1);
    s3 = sub_sq(s2);
    return sub_mul(sub_mul(s1, s2), s3);
  endfunction

  // all-ones equals zero in the field, so complement when the top bit is set
  function automatic subc_t sub_canon(sub_t a);
    return a[SUB_W-1] ? ~a[SUB_C-1:0] : a[SUB_C-1:0];
  endfunction

  function automatic sub_t sub_from4(subc_t c);
    return {1'b0, c};
  endfunction

  // y^2 + y + lam must have no root in the subfield
  function automatic sub_t find_lambda();
    sub_t lam;
    bit   ok;
    lam = '0;
    for (int c = 15; c >= 1; c--) begin
      ok = 1'b1;
      for (int t = 0; t < 16; t++) begin
        sub_t tt;
        tt = sub_from4(subc_t'(t));
        if (sub_canon(sub_mul(tt, tt) ^ tt) == subc_t'(c)) ok = 1'b0;
      end
      if (ok) lam = sub_from4(subc_t'(c));
    end
    return lam;
  endfunction

  // (ah y + al)(bh y + bl) with y^2 = y + lam
  function automatic twr_t twr_mul(twr_t a, twr_t b, sub_t lam);
    sub_t hh, hi, lo;
    hh = sub_mul(a[TWR_W-1:SUB_W], b[TWR_W-1:SUB_W]);
    hi = hh ^ sub_mul(a[TWR_W-1:SUB_W], b[SUB_W-1:0])
            ^ sub_mul(a[SUB_W-1:0], b[TWR_W-1:SUB_W]);
    lo = sub_mul(lam, hh) ^ sub_mul(a[SUB_W-1:0], b[SUB_W-1:0]);
    return {hi, lo};
  endfunction

  function automatic byte_t twr_canon(twr_t a);
    return {sub_canon(a[TWR_W-1:SUB_W]), sub_canon(a[SUB_W-1:0])};
  endfunction

  function automatic twr_t twr_from8(byte_t k);
    return {sub_from4(k[7:4]), sub_from4(k[3:0])};
  endfunction

  function automatic bit is_aes_root(twr_t b, sub_t lam);
    twr_t p2, p3, p4, p8, s;
    p2 = twr_mul(b, b, lam);
    p3 = twr_mul(p2, b, lam);
    p4 = twr_mul(p2, p2, lam);
    p8 = twr_mul(p4, p4, lam);
    s  = p8 ^ p4 ^ p3 ^ b ^ twr_from8(8'h01);
    return twr_canon(s) == 8'h00;
  endfunction

  function automatic int max_row_wt(fwd_mat_t m);
    int w, cnt;
    w = 0;
    for (int r = 0; r < TWR_W; r++) begin
      cnt = 0;
      for (int i = 0; i < BYTE_W; i++) cnt += int'(m[i][r]);
      if (cnt > w) w = cnt;
    end
    return w;
  endfunction

  // column i = image of x^i; root picked for lowest worst row weight
  function automatic fwd_mat_t build_fwd();
    sub_t     lam;
    fwd_mat_t best, m;
    int       bestw, w;
    twr_t     b;
    lam   = find_lambda();
    best  = '0;
    bestw = 1000;
    for (int k = 2; k < 256; k++) begin
      b = twr_from8(byte_t'(k));
      if (is_aes_root(b, lam)) begin
        m[0] = twr_from8(8'h01);
        for (int i = 1; i < BYTE_W; i++) m[i] = twr_mul(m[i-1], b, lam);
        w = max_row_wt(m);
        if (w < bestw) begin
          bestw = w;
          best  = m;
        end
      end
    end
    return best;
  endfunction

  function automatic twr_t fwd_apply(fwd_mat_t m, byte_t v);
    twr_t acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) if (v[i]) acc = acc ^ m[i];
    return acc;
  endfunction

  function automatic byte_t rotl8(byte_t v, int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t aff_lin(byte_t v);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4);
  endfunction

  // per redundant wire: back-map its field value, then the affine matrix
  function automatic out_mat_t build_out();
    fwd_mat_t f;
    out_mat_t o;
    byte_t    tgt;
    f = build_fwd();
    o = '0;
    for (int j = 0; j < TWR_W; j++) begin
      tgt = twr_canon(twr_t'(1) << j);
      for (int v = 0; v < 256; v++)
        if (twr_canon(fwd_apply(f, byte_t'(v))) == tgt) o[j] = aff_lin(byte_t'(v));
    end
    return o;
  endfunction

endpackage

// File: rtl/sbx_fwd_map.sv
module sbx_fwd_map
  import sbx_pkg::*;
#(
  parameter fwd_mat_t MAT = build_fwd()
) (
  input  byte_t din,
  output twr_t  tout
);

  always_comb begin
    tout = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (din[i]) tout = tout ^ MAT[i];
  end

  // an isomorphism sends no nonzero byte to zero
  always_comb begin
    if (din != '0) begin
      AST_FWD_INJECTIVE: assert (twr_canon(tout) != 8'h00) else $error("nonzero byte mapped to zero"); // R7
    end
  end

endmodule

// File: rtl/sbx_tower_inv.sv
module sbx_tower_inv
  import sbx_pkg::*;
#(
  parameter bit MID_REG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  twr_t a,
  output logic out_vld,
  output twr_t q
);

  localparam sub_t LAM = find_lambda();

  sub_t ah, al, nrm, ninv, conj_lo;
  sub_t s_ninv, s_hi, s_lo;

  // stage 1: norm a^17 = lam*ah^2 + ah*al + al^2 ; conjugate is (ah, ah^al)
  always_comb begin
    ah      = a[TWR_W-1:SUB_W];
    al      = a[SUB_W-1:0];
    nrm     = sub_mul(LAM, sub_mul(ah, ah)) ^ sub_mul(ah, al) ^ sub_mul(al, al);
    conj_lo = ah ^ al;
    // stage 2: subfield inversion
    ninv    = sub_inv(nrm);
  end

  always_comb begin
    if (twr_canon(a) != 8'h00) begin
      AST_NORM_NONZERO: assert (sub_canon(nrm) != '0) else $error("zero norm for nonzero input"); // R7
    end
    if (sub_canon(nrm) != '0) begin
      AST_SUB_INVERSE: assert (sub_canon(sub_mul(ninv, nrm)) == subc_t'(1)) else $error("subfield inverse wrong"); // R7
    end
  end

  generate
    if (MID_REG) begin : g_mid
      logic s_vld;
      always_ff @(posedge clk) begin
        if (rst) begin
          s_vld  <= 1'b0;
          s_ninv <= '0;
          s_hi   <= '0;
          s_lo   <= '0;
        end else begin
          s_vld <= in_vld;
          if (in_vld) begin
            s_ninv <= ninv;
            s_hi   <= ah;
            s_lo   <= conj_lo;
          end
        end
      end
      assign out_vld = s_vld;
    end else begin : g_flat
      assign s_ninv  = ninv;
      assign s_hi    = ah;
      assign s_lo    = conj_lo;
      assign out_vld = in_vld;
    end
  endgenerate

  // stage 3: scale the conjugate by the inverted norm
  assign q = {sub_mul(s_ninv, s_hi), sub_mul(s_ninv, s_lo)};

endmodule

// File: rtl/sbx_out_map.sv
module sbx_out_map
  import sbx_pkg::*;
#(
  parameter out_mat_t MAT   = build_out(),
  parameter byte_t    AFF_C = 8'h63
) (
  input  twr_t  tin,
  output byte_t sout
);

  always_comb begin
    sout = AFF_C;
    for (int j = 0; j < TWR_W; j++)
      if (tin[j]) sout = sout ^ MAT[j];
  end

  always_comb begin
    if (tin == '0) begin
      AST_ZERO_CONST: assert (sout == AFF_C) else $error("zero did not give affine constant"); // R3
    end
  end

endmodule

// File: rtl/sbx_subbytes.sv
module sbx_subbytes
  import sbx_pkg::*;
#(
  parameter bit    MID_REG = 1'b1,
  parameter byte_t AFF_C   = 8'h63
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din_vld,
  input  logic [7:0] din,
  output logic       dout_vld,
  output logic [7:0] dout
);

  localparam fwd_mat_t FWD = build_fwd();
  localparam out_mat_t OUTM = build_out();

  twr_t  t_in, t_inv;
  logic  inv_vld;
  byte_t s_res;

  sbx_fwd_map #(.MAT(FWD)) u_fwd (
    .din  (din),
    .tout (t_in)
  );

  sbx_tower_inv #(.MID_REG(MID_REG)) u_inv (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (din_vld),
    .a       (t_in),
    .out_vld (inv_vld),
    .q       (t_inv)
  );

  sbx_out_map #(.MAT(OUTM), .AFF_C(AFF_C)) u_out (
    .tin  (t_inv),
    .sout (s_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_vld <= 1'b0;
      dout     <= '0;
    end else begin
      dout_vld <= inv_vld;
      if (inv_vld) dout <= s_res;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (!dout_vld && dout == '0)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !inv_vld |=> $stable(dout)); // R5

  generate
    if (MID_REG) begin : g_lat2
      AST_LATENCY: assert property (@(posedge clk) disable iff (rst) din_vld |=> ##1 dout_vld); // R4
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !din_vld |=> ##1 !dout_vld); // R4
    end else begin : g_lat1
      AST_LATENCY: assert property (@(posedge clk) disable iff (rst) din_vld |=> dout_vld); // R4
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !din_vld |=> !dout_vld); // R4
    end
  endgenerate

endmodule

// File: tb/sbx_subbytes_tb_top.sv
`timescale 1ns/1ps
module sbx_subbytes_tb_top;

  localparam bit MID = 1'b1;
  localparam int LAT = 1 + int'(MID);

  typedef struct {
    logic [7:0] din;
    logic [7:0] exp;
    int         stamp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din_vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic       dout_vld;
  logic [7:0] dout;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit seen = 1'b0;
  logic [7:0] last = 8'h00;
  sb_item_t sbq[$];
  sb_item_t it;

  always #4 clk = ~clk;   // 125 MHz

  sbx_subbytes #(.MID_REG(MID)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .din_vld  (din_vld),
    .din      (din),
    .dout_vld (dout_vld),
    .dout     (dout)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] a);
    logic [7:0] inv, b;
    inv = 8'h00;
    for (int k = 1; k < 256; k++)
      if (gmul(a, 8'(k)) == 8'h01) inv = 8'(k);
    b = inv;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  task automatic send(input logic [7:0] v, input logic [7:0] e, input string tag);
    sb_item_t s;
    @(negedge clk);
    din     <= v;
    din_vld <= 1'b1;
    s.din = v; s.exp = e; s.stamp = cyc; s.tag = tag;
    sbq.push_back(s);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din_vld <= 1'b0;
      din     <= 8'(8'hA5 ^ (i * 37));   // junk must be ignored (R5)
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (dout_vld) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R4 unexpected valid", int'(dout), 0);
        end else begin
          it = sbq.pop_front();
          chk(dout == it.exp, it.tag, int'(dout), int'(it.exp));
          chk(cyc - it.stamp == LAT, "R4 latency", cyc - it.stamp, LAT);
          chk((it.din == 8'h00) == (dout == 8'h63), "R7 zero code", int'(dout), int'(it.exp));
          last = dout;
          seen = 1'b1;
        end
      end else if (seen) begin
        chk(dout == last, "R5 hold", int'(dout), int'(last));
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!dout_vld && dout == 8'h00, "R1 during reset", int'({dout_vld, dout}), 0);
    repeat (2) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(!dout_vld && dout == 8'h00, "R1 after reset", int'({dout_vld, dout}), 0);

    // known table values
    send(8'h00, 8'h63, "R3 zero input");
    idle(3);
    send(8'h53, 8'hED, "R2 known 0x53");
    send(8'h01, 8'h7C, "R2 known 0x01");
    idle(2);
    send(8'hFF, 8'h16, "R2 known 0xFF");
    idle(4);

    // full sweep, back to back, ascending (R2, R6)
    for (int v = 0; v < 256; v++) send(8'(v), ref_sbox(8'(v)), "R2/R6 sweep up");
    idle(6);

    // descending with gaps every fifth byte
    for (int v = 255; v >= 0; v -= 3) begin
      send(8'(v), ref_sbox(8'(v)), "R2 sweep down");
      if (v % 5 == 0) idle(2);
    end
    idle(LAT + 4);

    chk(sbq.size() == 0, "R4 all results delivered", sbq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule